// File: doc/BRIEF.md
# Exception and Interrupt Entry Sequencer

This block sits at the instruction-boundary point of a processor core. At each boundary it looks at a pending synchronous exception code and a pending external interrupt, with its priority level and event code. It picks at most one of them and carries out the entry into the handler. The entry saves the program counter, the status word and the stack pointer register R15. It raises the blocked, privileged and register-bank bits of the status word, records the event code and computes the handler address from the vector base.

A synchronous exception that arrives while the blocked bit is already set cannot be handled safely, so the block turns it into a reset. One code is exempt from this conversion. Interrupts are gated twice. They are held off entirely while the status word is blocked, and they are accepted only when their level is strictly above the four-bit mask field of the status word.

Entry takes two clock edges. The edge that sees the boundary strobe captures the decision and its operands and raises `busy_o`. The following edge writes every architectural output and pulses `take_o` for one cycle.

Top module: `exc_entry_seq`

## Requirements
- R1: When a boundary sees both an exception request and an interrupt request, the exception is taken. `expevt_o` receives the exception code, and `intevt_o` keeps its previous value.
- R2: With status bit 28 (blocked) set, an exception whose code is not 0x1E0 is entered as a reset. `expevt_o` becomes 0x000, `pc_o` becomes 0xA0000000, and status bits 7:4 become 0xF.
- R3: With status bit 28 set, exception code 0x1E0 is entered as an ordinary exception. `expevt_o` becomes 0x1E0, `pc_o` becomes base + 0x100, and the mask bits 7:4 stay unchanged.
- R4: An interrupt is accepted only if its level is greater than status bits 7:4. A level equal to or below the mask causes no busy, no take and no output change.
- R5: While status bit 28 is set, an interrupt causes no entry at all. The same request is accepted at a later boundary once the bit is clear.
- R6: On every entry `ssr_o` holds the old status word, `spc_o` the old PC (except under R9) and `sgr_o` the old R15. `sr_o` equals the old status word with bits 28, 29 and 30 set, plus the mask change of R2 for a reset.
- R7: Exception codes 0x040 and 0x060 branch to base + 0x400. Any other non-reset exception branches to base + 0x100.
- R8: An accepted interrupt writes its code to `intevt_o`, branches to base + 0x600 and leaves `expevt_o` unchanged.
- R9: Exception code 0x160 (trap) saves PC + 2 in `spc_o`.
- R10: `busy_o` is high in the cycle after the accepting boundary. `take_o` is high for exactly the next cycle, together with the new outputs. A boundary seen while busy is ignored.
- R11: After reset every output is zero, with `busy_o` and `take_o` low.
- R12: Without a boundary strobe, pending requests cause no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boundary_i | input | 1 | Instruction boundary strobe; the decision is made here |
| exc_valid_i | input | 1 | A synchronous exception is pending |
| exc_code_i | input | 12 | Event code of the pending exception |
| irq_valid_i | input | 1 | An external interrupt is pending |
| irq_level_i | input | 4 | Priority level of the pending interrupt |
| irq_code_i | input | 12 | Event code of the pending interrupt |
| sr_i | input | 32 | Current status word |
| vbr_i | input | 32 | Vector base address |
| pc_i | input | 32 | PC of the interrupted instruction |
| r15_i | input | 32 | Current R15 value |
| busy_o | output | 1 | Entry accepted and in progress |
| take_o | output | 1 | One-cycle pulse: entry outputs are valid |
| sr_o | output | 32 | Status word after entry |
| ssr_o | output | 32 | Saved status word |
| spc_o | output | 32 | Saved PC |
| sgr_o | output | 32 | Saved R15 |
| expevt_o | output | 12 | Exception event code |
| intevt_o | output | 12 | Interrupt event code |
| pc_o | output | 32 | Handler address |

## Verification
Exceptions are driven with plain codes, with the two TLB-miss codes and with the trap code. The results show whether the base offset and the saved-PC adjustment depend on the right codes. Each class is repeated with the blocked bit set, once with an ordinary code and once with the exempt code, to separate reset conversion from normal entry. Interrupts are presented with the level above, equal to and below the mask, while blocked, and together with an exception. This pins down the strict comparison, the hold-off and the priority. Back-to-back boundary strobes and pending requests without a strobe show that only one entry starts per accepted boundary.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    localparam int SR_BL_BIT    = 28;
    localparam int SR_RB_BIT    = 29;
    localparam int SR_MD_BIT    = 30;
    localparam int SR_IMASK_LO  = 4;
    localparam int IMASK_W      = 4;
    localparam int SR_IMASK_HI  = SR_IMASK_LO + IMASK_W - 1;

    typedef enum logic [1:0] {
        EV_NONE  = 2'd0,
        EV_RESET = 2'd1,
        EV_EXC   = 2'd2,
        EV_IRQ   = 2'd3
    } ev_kind_e;

endpackage

// File: rtl/evt_arbiter.sv
module evt_arbiter
    import exc_entry_pkg::*;
#(
    parameter int                CODE_W      = 12,
    parameter logic [CODE_W-1:0] EXEMPT_CODE = 12'h1E0,
    parameter logic [CODE_W-1:0] RESET_CODE  = 12'h000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                eval_i,
    input  logic                exc_valid_i,
    input  logic [CODE_W-1:0]   exc_code_i,
    input  logic                irq_valid_i,
    input  logic [IMASK_W-1:0]  irq_level_i,
    input  logic [CODE_W-1:0]   irq_code_i,
    input  logic                blocked_i,
    input  logic [IMASK_W-1:0]  imask_i,
    output ev_kind_e            kind_o,
    output logic [CODE_W-1:0]   code_o
);

    logic irq_ok;

    always_comb begin
        irq_ok = irq_valid_i && !blocked_i && (irq_level_i > imask_i);
        kind_o = EV_NONE;
        code_o = '0;
        if (eval_i) begin
            if (exc_valid_i) begin
                if ((blocked_i && exc_code_i != EXEMPT_CODE) || exc_code_i == RESET_CODE) begin
                    kind_o = EV_RESET;
                    code_o = RESET_CODE;
                end else begin
                    kind_o = EV_EXC;
                    code_o = exc_code_i;
                end
            end else if (irq_ok) begin
                kind_o = EV_IRQ;
                code_o = irq_code_i;
            end
        end
    end

    // R1
    exc_over_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_i && exc_valid_i) |-> (kind_o != EV_IRQ));

    // R4
    irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_o == EV_IRQ) |-> (irq_level_i > imask_i));

    // R5
    irq_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_o == EV_IRQ) |-> !blocked_i);

endmodule

// File: rtl/vec_select.sv
module vec_select
    import exc_entry_pkg::*;
#(
    parameter int                       XLEN      = 32,
    parameter int                       CODE_W    = 12,
    parameter int                       N_TLB     = 2,
    parameter logic [N_TLB*CODE_W-1:0]  TLB_CODES = {12'h060, 12'h040},
    parameter logic [XLEN-1:0]          RESET_PC  = 32'hA000_0000,
    parameter logic [XLEN-1:0]          OFS_GEN   = 32'h0000_0100,
    parameter logic [XLEN-1:0]          OFS_TLB   = 32'h0000_0400,
    parameter logic [XLEN-1:0]          OFS_IRQ   = 32'h0000_0600
) (
    input  ev_kind_e            kind_i,
    input  logic [CODE_W-1:0]   code_i,
    input  logic [XLEN-1:0]     vbr_i,
    output logic [XLEN-1:0]     pc_o
);

    logic [N_TLB-1:0] tlb_hit;

    for (genvar g = 0; g < N_TLB; g++) begin : g_tlb
        assign tlb_hit[g] = (code_i == TLB_CODES[g*CODE_W +: CODE_W]);
    end

    always_comb begin
        unique case (kind_i)
            EV_RESET: pc_o = RESET_PC;
            EV_IRQ:   pc_o = vbr_i + OFS_IRQ;
            EV_EXC:   pc_o = vbr_i + ((|tlb_hit) ? OFS_TLB : OFS_GEN);
            default:  pc_o = '0;
        endcase
    end

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_entry_pkg::*;
#(
    parameter int                XLEN        = 32,
    parameter int                CODE_W      = 12,
    parameter logic [CODE_W-1:0] EXEMPT_CODE = 12'h1E0,
    parameter logic [CODE_W-1:0] RESET_CODE  = 12'h000,
    parameter logic [CODE_W-1:0] TRAP_CODE   = 12'h160,
    parameter logic [XLEN-1:0]   RESET_PC    = 32'hA000_0000,
    parameter logic [XLEN-1:0]   TRAP_STEP   = 32'd2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                boundary_i,
    input  logic                exc_valid_i,
    input  logic [CODE_W-1:0]   exc_code_i,
    input  logic                irq_valid_i,
    input  logic [IMASK_W-1:0]  irq_level_i,
    input  logic [CODE_W-1:0]   irq_code_i,
    input  logic [XLEN-1:0]     sr_i,
    input  logic [XLEN-1:0]     vbr_i,
    input  logic [XLEN-1:0]     pc_i,
    input  logic [XLEN-1:0]     r15_i,
    output logic                busy_o,
    output logic                take_o,
    output logic [XLEN-1:0]     sr_o,
    output logic [XLEN-1:0]     ssr_o,
    output logic [XLEN-1:0]     spc_o,
    output logic [XLEN-1:0]     sgr_o,
    output logic [CODE_W-1:0]   expevt_o,
    output logic [CODE_W-1:0]   intevt_o,
    output logic [XLEN-1:0]     pc_o
);

    localparam logic [XLEN-1:0] ENTRY_SET =
        (XLEN'(1) << SR_BL_BIT) | (XLEN'(1) << SR_MD_BIT) | (XLEN'(1) << SR_RB_BIT);
    localparam logic [XLEN-1:0] IMASK_ALL = XLEN'({IMASK_W{1'b1}}) << SR_IMASK_LO;

    typedef struct packed {
        logic               busy;
        logic               take;
        ev_kind_e           kind;
        logic [CODE_W-1:0]  code;
        logic [XLEN-1:0]    snap_sr;
        logic [XLEN-1:0]    snap_vbr;
        logic [XLEN-1:0]    snap_pc;
        logic [XLEN-1:0]    snap_r15;
        logic [XLEN-1:0]    sr;
        logic [XLEN-1:0]    ssr;
        logic [XLEN-1:0]    spc;
        logic [XLEN-1:0]    sgr;
        logic [CODE_W-1:0]  expevt;
        logic [CODE_W-1:0]  intevt;
        logic [XLEN-1:0]    pc;
    } state_t;

    state_t st_d, st_q;

    ev_kind_e          arb_kind;
    logic [CODE_W-1:0] arb_code;
    logic [XLEN-1:0]   handler_pc;
    logic              accept;

    assign accept = boundary_i && !st_q.busy;

    evt_arbiter #(
        .CODE_W      (CODE_W),
        .EXEMPT_CODE (EXEMPT_CODE),
        .RESET_CODE  (RESET_CODE)
    ) u_arb (
        .clk         (clk),
        .rst_n       (rst_n),
        .eval_i      (accept),
        .exc_valid_i (exc_valid_i),
        .exc_code_i  (exc_code_i),
        .irq_valid_i (irq_valid_i),
        .irq_level_i (irq_level_i),
        .irq_code_i  (irq_code_i),
        .blocked_i   (sr_i[SR_BL_BIT]),
        .imask_i     (sr_i[SR_IMASK_HI:SR_IMASK_LO]),
        .kind_o      (arb_kind),
        .code_o      (arb_code)
    );

    vec_select #(
        .XLEN     (XLEN),
        .CODE_W   (CODE_W),
        .RESET_PC (RESET_PC)
    ) u_vec (
        .kind_i   (st_q.kind),
        .code_i   (st_q.code),
        .vbr_i    (st_q.snap_vbr),
        .pc_o     (handler_pc)
    );

    always_comb begin
        st_d      = st_q;
        st_d.take = 1'b0;

        if (st_q.busy) begin
            st_d.busy = 1'b0;
            st_d.take = 1'b1;
            st_d.ssr  = st_q.snap_sr;
            st_d.sgr  = st_q.snap_r15;
            st_d.spc  = st_q.snap_pc;
            st_d.sr   = st_q.snap_sr | ENTRY_SET;
            st_d.pc   = handler_pc;
            unique case (st_q.kind)
                EV_RESET: begin
                    st_d.sr     = st_q.snap_sr | ENTRY_SET | IMASK_ALL;
                    st_d.expevt = st_q.code;
                end
                EV_EXC: begin
                    st_d.expevt = st_q.code;
                    if (st_q.code == TRAP_CODE) begin
                        st_d.spc = st_q.snap_pc + TRAP_STEP;
                    end
                end
                EV_IRQ: begin
                    st_d.intevt = st_q.code;
                end
                default: begin
                    st_d.take = 1'b0;
                end
            endcase
        end else if (arb_kind != EV_NONE) begin
            st_d.busy     = 1'b1;
            st_d.kind     = arb_kind;
            st_d.code     = arb_code;
            st_d.snap_sr  = sr_i;
            st_d.snap_vbr = vbr_i;
            st_d.snap_pc  = pc_i;
            st_d.snap_r15 = r15_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o   = st_q.busy;
    assign take_o   = st_q.take;
    assign sr_o     = st_q.sr;
    assign ssr_o    = st_q.ssr;
    assign spc_o    = st_q.spc;
    assign sgr_o    = st_q.sgr;
    assign expevt_o = st_q.expevt;
    assign intevt_o = st_q.intevt;
    assign pc_o     = st_q.pc;

    // R10
    take_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !take_o);

    // R10
    busy_then_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (take_o && !busy_o));

    // R6
    entry_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (sr_o[SR_BL_BIT] && sr_o[SR_MD_BIT] && sr_o[SR_RB_BIT]));

    // R2
    reset_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && st_q.kind == EV_RESET) |-> (pc_o == RESET_PC && expevt_o == RESET_CODE));

    // R6
    saved_sr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (ssr_o == $past(st_q.snap_sr)));

endmodule

// File: tb/tb_exc_entry_seq.sv
module tb_exc_entry_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boundary_i = 1'b0;
    logic        exc_valid_i = 1'b0;
    logic [11:0] exc_code_i = '0;
    logic        irq_valid_i = 1'b0;
    logic [3:0]  irq_level_i = '0;
    logic [11:0] irq_code_i = '0;
    logic [31:0] sr_i = '0;
    logic [31:0] vbr_i = '0;
    logic [31:0] pc_i = '0;
    logic [31:0] r15_i = '0;
    logic        busy_o, take_o;
    logic [31:0] sr_o, ssr_o, spc_o, sgr_o, pc_o;
    logic [11:0] expevt_o, intevt_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    localparam logic [31:0] ENTRY = 32'h7000_0000;
    localparam logic [31:0] VBR   = 32'h8C00_0000;

    always #4 clk = ~clk;

    exc_entry_seq dut (
        .clk(clk), .rst_n(rst_n), .boundary_i(boundary_i),
        .exc_valid_i(exc_valid_i), .exc_code_i(exc_code_i),
        .irq_valid_i(irq_valid_i), .irq_level_i(irq_level_i), .irq_code_i(irq_code_i),
        .sr_i(sr_i), .vbr_i(vbr_i), .pc_i(pc_i), .r15_i(r15_i),
        .busy_o(busy_o), .take_o(take_o), .sr_o(sr_o), .ssr_o(ssr_o),
        .spc_o(spc_o), .sgr_o(sgr_o), .expevt_o(expevt_o), .intevt_o(intevt_o),
        .pc_o(pc_o)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic set_ctx(input logic [31:0] sr, input logic [31:0] pc, input logic [31:0] r15);
        sr_i = sr; pc_i = pc; r15_i = r15; vbr_i = VBR;
    endtask

    task automatic clear_req();
        exc_valid_i = 1'b0; irq_valid_i = 1'b0; boundary_i = 1'b0;
    endtask

    // Pulse boundary, check busy then take; on return the entry outputs are valid.
    task automatic fire_entry(input string req);
        boundary_i = 1'b1;
        @(negedge clk);
        boundary_i = 1'b0;
        chk(busy_o === 1'b1 && take_o === 1'b0, req, {30'd0, busy_o, take_o}, 32'h2);
        @(negedge clk);
        chk(take_o === 1'b1 && busy_o === 1'b0, req, {30'd0, busy_o, take_o}, 32'h1);
    endtask

    // Pulse boundary and expect nothing to start.
    task automatic fire_none(input string req);
        logic [31:0] pc0, sr0;
        logic [11:0] ee0, ie0;
        pc0 = pc_o; sr0 = sr_o; ee0 = expevt_o; ie0 = intevt_o;
        boundary_i = 1'b1;
        @(negedge clk);
        boundary_i = 1'b0;
        chk(busy_o === 1'b0, req, {31'd0, busy_o}, 32'h0);
        @(negedge clk);
        chk(take_o === 1'b0, req, {31'd0, take_o}, 32'h0);
        chk(pc_o === pc0 && sr_o === sr0 && expevt_o === ee0 && intevt_o === ie0,
            req, pc_o, pc0);
    endtask

    task automatic t_reset_state();
        chk(busy_o === 1'b0 && take_o === 1'b0, "R11 flags", {30'd0, busy_o, take_o}, 32'h0);
        chk(sr_o === '0 && ssr_o === '0 && spc_o === '0 && sgr_o === '0, "R11 regs", sr_o, 32'h0);
        chk(pc_o === '0 && expevt_o === '0 && intevt_o === '0, "R11 evt", pc_o, 32'h0);
    endtask

    task automatic t_general_exc();
        set_ctx(32'h0000_0030, 32'h8C00_1000, 32'h0000_1234);
        exc_valid_i = 1'b1; exc_code_i = 12'h180;
        fire_entry("R10 general");
        chk(sr_o === (32'h30 | ENTRY), "R6 sr", sr_o, 32'h30 | ENTRY);
        chk(ssr_o === 32'h30, "R6 ssr", ssr_o, 32'h30);
        chk(spc_o === 32'h8C00_1000, "R6 spc", spc_o, 32'h8C00_1000);
        chk(sgr_o === 32'h1234, "R6 sgr", sgr_o, 32'h1234);
        chk(expevt_o === 12'h180, "R7 code", {20'd0, expevt_o}, 32'h180);
        chk(pc_o === VBR + 32'h100, "R7 general offset", pc_o, VBR + 32'h100);
        clear_req();
    endtask

    task automatic t_tlb(input logic [11:0] code);
        set_ctx(32'h0, 32'h0040_0000, 32'h55);
        exc_valid_i = 1'b1; exc_code_i = code;
        fire_entry("R7 tlb");
        chk(pc_o === VBR + 32'h400, "R7 tlb offset", pc_o, VBR + 32'h400);
        chk(expevt_o === code, "R7 tlb code", {20'd0, expevt_o}, {20'd0, code});
        clear_req();
    endtask

    task automatic t_trap();
        set_ctx(32'h0, 32'h0000_2000, 32'h9);
        exc_valid_i = 1'b1; exc_code_i = 12'h160;
        fire_entry("R9 trap");
        chk(spc_o === 32'h0000_2002, "R9 spc", spc_o, 32'h2002);
        chk(pc_o === VBR + 32'h100, "R9 vector", pc_o, VBR + 32'h100);
        clear_req();
    endtask

    task automatic t_exc_over_irq();
        logic [11:0] ie0;
        ie0 = intevt_o;
        set_ctx(32'h0, 32'h0000_3000, 32'h1);
        exc_valid_i = 1'b1; exc_code_i = 12'h0E0;
        irq_valid_i = 1'b1; irq_level_i = 4'hF; irq_code_i = 12'h200;
        fire_entry("R1 prio");
        chk(expevt_o === 12'h0E0, "R1 expevt", {20'd0, expevt_o}, 32'h0E0);
        chk(intevt_o === ie0, "R1 intevt kept", {20'd0, intevt_o}, {20'd0, ie0});
        chk(pc_o === VBR + 32'h100, "R1 vector", pc_o, VBR + 32'h100);
        clear_req();
    endtask

    task automatic t_blocked_reset();
        set_ctx(32'h1000_0000, 32'h0000_4000, 32'h2);
        exc_valid_i = 1'b1; exc_code_i = 12'h100;
        fire_entry("R2 blocked");
        chk(expevt_o === 12'h000, "R2 code", {20'd0, expevt_o}, 32'h0);
        chk(pc_o === 32'hA000_0000, "R2 pc", pc_o, 32'hA000_0000);
        chk(sr_o === 32'h7000_00F0, "R2 sr mask", sr_o, 32'h7000_00F0);
        clear_req();
    endtask

    task automatic t_blocked_exempt();
        set_ctx(32'h1000_0020, 32'h0000_5000, 32'h3);
        exc_valid_i = 1'b1; exc_code_i = 12'h1E0;
        fire_entry("R3 exempt");
        chk(expevt_o === 12'h1E0, "R3 code", {20'd0, expevt_o}, 32'h1E0);
        chk(pc_o === VBR + 32'h100, "R3 pc", pc_o, VBR + 32'h100);
        chk(sr_o === 32'h7000_0020, "R3 sr", sr_o, 32'h7000_0020);
        clear_req();
    endtask

    task automatic t_irq();
        logic [11:0] ee0;
        ee0 = expevt_o;
        set_ctx(32'h0000_0030, 32'h0000_6000, 32'h4);
        irq_valid_i = 1'b1; irq_level_i = 4'h4; irq_code_i = 12'h320;
        fire_entry("R8 irq");
        chk(intevt_o === 12'h320, "R8 intevt", {20'd0, intevt_o}, 32'h320);
        chk(pc_o === VBR + 32'h600, "R8 pc", pc_o, VBR + 32'h600);
        chk(expevt_o === ee0, "R8 expevt kept", {20'd0, expevt_o}, {20'd0, ee0});
        clear_req();
    endtask

    task automatic t_irq_masked();
        set_ctx(32'h0000_0030, 32'h0000_7000, 32'h5);
        irq_valid_i = 1'b1; irq_level_i = 4'h3; irq_code_i = 12'h340;
        fire_none("R4 equal level");
        irq_level_i = 4'h1;
        fire_none("R4 lower level");
        clear_req();
    endtask

    task automatic t_irq_blocked();
        set_ctx(32'h1000_0000, 32'h0000_8000, 32'h6);
        irq_valid_i = 1'b1; irq_level_i = 4'hF; irq_code_i = 12'h3A0;
        fire_none("R5 blocked");
        sr_i = 32'h0;
        fire_entry("R5 released");
        chk(intevt_o === 12'h3A0, "R5 intevt", {20'd0, intevt_o}, 32'h3A0);
        clear_req();
    endtask

    task automatic t_no_boundary();
        set_ctx(32'h0, 32'h0000_9000, 32'h7);
        exc_valid_i = 1'b1; exc_code_i = 12'h1A0;
        repeat (3) @(negedge clk);
        chk(busy_o === 1'b0 && take_o === 1'b0, "R12 idle", {30'd0, busy_o, take_o}, 32'h0);
        chk(expevt_o !== 12'h1A0, "R12 no write", {20'd0, expevt_o}, 32'h0);
        clear_req();
    endtask

    task automatic t_busy_ignore();
        set_ctx(32'h0, 32'h0000_A000, 32'h8);
        exc_valid_i = 1'b1; exc_code_i = 12'h0E0;
        boundary_i = 1'b1;
        @(negedge clk);
        exc_code_i = 12'h1C0;
        chk(busy_o === 1'b1, "R10 busy", {31'd0, busy_o}, 32'h1);
        @(negedge clk);
        boundary_i = 1'b0;
        chk(take_o === 1'b1 && expevt_o === 12'h0E0, "R10 first kept",
            {20'd0, expevt_o}, 32'h0E0);
        clear_req();
        @(negedge clk);
        chk(busy_o === 1'b0 && take_o === 1'b0, "R10 no second", {30'd0, busy_o, take_o}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_no_boundary();
        t_general_exc();
        t_tlb(12'h040);
        t_tlb(12'h060);
        t_trap();
        t_exc_over_irq();
        t_blocked_reset();
        t_blocked_exempt();
        t_irq();
        t_irq_masked();
        t_irq_blocked();
        t_busy_ignore();
        repeat (2) @(negedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                chk(1'b0, "watchdog", 32'h0, 32'h1);
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule